// File: doc/BRIEF.md
# Pulse Insert/Delete Oscillator Stage

This block is the digitally controlled oscillator stage of a digital phase-locked loop. It turns its input clock into an output pulse stream at exactly half the input rate. Its output `dco_o` is a one-cycle-wide count strobe: with no correction requests it is high on every second input clock cycle. A downstream divide-by-N counter uses `dco_o` as its count enable, and the loop is closed through it. With the input clock at 2N times the loop centre frequency, the idle strobe rate is N times the centre frequency.

The up/down loop counter drives two single-cycle request lines into this stage. A carry request adds exactly one strobe, which advances the loop phase. A borrow request removes exactly one strobe, which retards it. Requests are captured into pending flags and serviced at the next suitable slot.

A free-running slot phase alternates between two kinds of cycle. In a fire slot a strobe is normally emitted. In a hold slot no strobe is normally emitted. An add fills the next hold slot, and a delete blanks the next fire slot. Opposite requests that are pending together cancel each other. A repeated request of the same kind that arrives while one is still waiting is merged with it and reported on an overflow pulse.

Top module: `halfrate_dco`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the slot phase, both pending flags, `dco_o` and `ovf_o`. In the first cycle after reset is released, `dco_o` is low. In the second cycle after release it is high.
- R2: With nothing pending, `dco_o` alternates every cycle, so any window of an even number of cycles holds exactly half as many high cycles.
- R3: A carry pulse (`carry_i` high for one cycle) adds exactly one high cycle to `dco_o`. The extra strobe is placed in the first hold slot after capture, where `dco_o` would otherwise be low.
- R4: A borrow pulse (`borrow_i` high for one cycle) removes exactly one high cycle from `dco_o`. The removed strobe is the one in the first fire slot after capture.
- R5: A request is held in a pending flag until serviced, and each captured request is serviced exactly once. Well-spaced requests therefore change the strobe count by exactly their number.
- R6: When a carry and a borrow are both pending, both flags are cleared at the next edge and `dco_o` keeps its idle pattern. This includes requests that arrive in the same cycle, and none of these cases raises `ovf_o`.
- R7: A request that arrives while a request of the same kind is pending, and is not being serviced at that edge, is merged with it: the net effect is one add or one delete. `ovf_o` is high for exactly one cycle, the cycle after the merging edge.
- R8: A request that arrives at the same edge where its pending flag is being serviced is not merged. It stays pending for the next slot, so two adds or two deletes result, and `ovf_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock (2N times the loop centre frequency) |
| rst | input | 1 | Synchronous reset, active high |
| carry_i | input | 1 | Single-cycle request to insert one strobe |
| borrow_i | input | 1 | Single-cycle request to delete one strobe |
| dco_o | output | 1 | Output count strobe, high on one of every two cycles when idle |
| ovf_o | output | 1 | One-cycle pulse when a same-kind request is merged |

## Verification
The strobe stream is measured by counting high cycles over even-length windows. In this measure, idle running gives exactly half the window. A single carry gives one more than half and a single borrow one less, so a misplaced or repeated service shows up as a count error. Trains of spaced requests separate one-shot servicing from sticky flags. Simultaneous opposite requests check that cancellation leaves the count unchanged. Back-to-back requests of the same kind are issued twice, once aligned so that the second arrives in a non-servicing slot and once so that it lands on the servicing edge. This pair tells merging with overflow apart from a legitimate second service.

// File: rtl/halfrate_dco.sv
module halfrate_dco (
  input  logic clk,
  input  logic rst,
  input  logic carry_i,
  input  logic borrow_i,
  output logic dco_o,
  output logic ovf_o
);

  logic ph;
  logic add_p;
  logic del_p;

  wire cancel = add_p & del_p;
  wire do_add = add_p & ~del_p & ~ph;
  wire do_del = del_p & ~add_p & ph;
  wire add_keep = add_p & ~do_add & ~cancel;
  wire del_keep = del_p & ~do_del & ~cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= 1'b0;
      add_p <= 1'b0;
      del_p <= 1'b0;
      dco_o <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      ph    <= ~ph;
      dco_o <= (ph & ~do_del) | do_add;
      add_p <= add_keep | carry_i;
      del_p <= del_keep | borrow_i;
      ovf_o <= (carry_i & add_keep) | (borrow_i & del_keep);
    end
  end

endmodule

module halfrate_dco_chk (
  input logic clk,
  input logic rst,
  input logic carry_i,
  input logic borrow_i,
  input logic dco_o,
  input logic ovf_o,
  input logic ph,
  input logic add_p,
  input logic del_p
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!dco_o && !ovf_o && !add_p && !del_p));

  a_r2_idle_alternate: assert property (@(posedge clk) disable iff (rst)
    (armed && !add_p && !del_p && $past(!add_p && !del_p)) |=> (dco_o != $past(dco_o)));

  a_r3_add_fills_hold: assert property (@(posedge clk) disable iff (rst)
    (add_p && !del_p && !ph && !carry_i) |=> (dco_o && !add_p));

  a_r4_del_blanks_fire: assert property (@(posedge clk) disable iff (rst)
    (del_p && !add_p && ph && !borrow_i) |=> (!dco_o && !del_p));

  a_r6_cancel_clears: assert property (@(posedge clk) disable iff (rst)
    (add_p && del_p && !carry_i && !borrow_i) |=> (!add_p && !del_p));

  a_r7_ovf_needs_request: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> $past(carry_i || borrow_i));

  a_r7_ovf_single: assert property (@(posedge clk) disable iff (rst)
    ovf_o && !$past(carry_i && add_p) && !$past(borrow_i && del_p) |-> 1'b0);

endmodule

bind halfrate_dco halfrate_dco_chk u_chk (
  .clk(clk), .rst(rst), .carry_i(carry_i), .borrow_i(borrow_i),
  .dco_o(dco_o), .ovf_o(ovf_o), .ph(ph), .add_p(add_p), .del_p(del_p)
);

// File: tb/halfrate_dco_tb.sv
module halfrate_dco_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carry_i = 1'b0;
  logic borrow_i = 1'b0;
  logic dco_o;
  logic ovf_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  halfrate_dco u_dut (
    .clk(clk), .rst(rst), .carry_i(carry_i), .borrow_i(borrow_i),
    .dco_o(dco_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_window(input int w, input int cmask_a, input int cmask_b,
                            input int bmask_a, input int bmask_b,
                            output int highs, output int ovfs);
    highs = 0;
    ovfs = 0;
    for (int i = 0; i < w; i++) begin
      carry_i  = ((i == cmask_a) || (i == cmask_b));
      borrow_i = ((i == bmask_a) || (i == bmask_b));
      @(posedge clk);
      @(negedge clk);
      carry_i  = 1'b0;
      borrow_i = 1'b0;
      highs += int'(dco_o);
      ovfs  += int'(ovf_o);
    end
  endtask

  task automatic align(input logic want_dco);
    while (dco_o !== want_dco) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 dco during reset", int'(dco_o), 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 first cycle after release", int'(dco_o), 0);
    check("R1 ovf after release", int'(ovf_o), 0);
    @(posedge clk); @(negedge clk);
    check("R1 second cycle after release", int'(dco_o), 1);
  endtask

  task automatic t_idle;
    int h, o;
    run_window(40, -1, -1, -1, -1, h, o);
    check("R2 idle high count", h, 20);
    check("R2 idle ovf", o, 0);
  endtask

  task automatic t_carry;
    int h, o;
    run_window(40, 2, -1, -1, -1, h, o);
    check("R3 single carry count", h, 21);
    check("R3 single carry ovf", o, 0);
  endtask

  task automatic t_borrow;
    int h, o;
    run_window(40, -1, -1, 3, -1, h, o);
    check("R4 single borrow count", h, 19);
    check("R4 single borrow ovf", o, 0);
  endtask

  task automatic t_trains;
    int h, o;
    run_window(30, 1, 9, -1, -1, h, o);
    check("R5 two spaced carries", h, 17);
    run_window(30, -1, -1, 2, 11, h, o);
    check("R5 two spaced borrows", h, 13);
    run_window(40, 2, -1, 15, -1, h, o);
    check("R5 carry then borrow", h, 20);
  endtask

  task automatic t_cancel;
    int h, o;
    run_window(40, 4, -1, 4, -1, h, o);
    check("R6 simultaneous cancel count", h, 20);
    check("R6 simultaneous cancel ovf", o, 0);
    align(1'b1);
    run_window(40, 4, -1, 5, -1, h, o);
    check("R6 adjacent opposite count", h, 20);
  endtask

  task automatic t_merge;
    int h, o;
    align(1'b1);
    run_window(40, 0, 1, -1, -1, h, o);
    check("R7 carry merge count", h, 21);
    check("R7 carry merge ovf", o, 1);
    align(1'b0);
    run_window(40, 0, 1, -1, -1, h, o);
    check("R8 carry on service edge count", h, 22);
    check("R8 carry on service edge ovf", o, 0);
    align(1'b0);
    run_window(40, -1, -1, 0, 1, h, o);
    check("R7 borrow merge count", h, 19);
    check("R7 borrow merge ovf", o, 1);
    align(1'b1);
    run_window(40, -1, -1, 0, 1, h, o);
    check("R8 borrow on service edge count", h, 18);
    check("R8 borrow on service edge ovf", o, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_carry();
    t_borrow();
    t_trains();
    t_cancel();
    t_merge();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule